// File: doc/BRIEF.md
# Asynchronous Serial Receive Path with Line Error Tagging

This block turns an asynchronous serial input into parallel characters. It watches the receive line using a tick that runs at sixteen times the bit rate. When the line falls, it counts to the middle of the start bit and checks the line again. It then samples every data bit, the optional parity bit and the stop bit at the middle of its bit period. Each finished character goes into a small first-in first-out queue. Its parity, framing and break tags are stored with it.

A reader sees the oldest queued character on the head outputs, together with that character's own tags. Pulsing the pop input removes the character. If a character completes while the queue is full, it is dropped and a sticky overrun flag is raised. The word length and the parity settings are plain configuration inputs. The oversampling tick comes from an external rate generator.

Top module: `rx_line_unit`

## Requirements
- R1: After a synchronous reset, `rd_valid` and `ovr_err` are 0.
- R2: A low pulse on `rxd` that has ended before the mid-point of the start bit (8 ticks after the falling edge) is discarded, and no character is queued.
- R3: Data bits are taken least significant bit first. `cfg_wlen` selects 5, 6, 7 or 8 data bits (codes 00, 01, 10 and 11). Bits of `rd_data` above the word length read 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. With `cfg_par_odd` at 0 the data bits and the parity bit together must hold an even number of ones; with 1, an odd number. A mismatch sets `rd_perr` for that character.
- R5: A stop bit sampled low sets `rd_ferr` for that character. The character is still queued.
- R6: If the line is low at every sample point of a frame, including the stop bit, exactly one character is queued, with data 0 and both `rd_brk` and `rd_ferr` set. No further character is taken until the line has returned high.
- R7: Characters come out in arrival order. The head outputs show the data and tags of the oldest character while `rd_valid` is 1.
- R8: A character that completes while the queue holds `DEPTH` entries is discarded, `ovr_err` goes to 1, and the queued characters stay unchanged.
- R9: `ovr_err` stays at 1 until a cycle with `rd_pop` at 1 clears it.
- R10: `rd_pop` while the queue is empty does not change the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_wlen | input | 2 | Word length code: 5, 6, 7 or 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| rd_pop | input | 1 | Remove the head character |
| rd_valid | output | 1 | Queue holds at least one character |
| rd_data | output | 8 | Head character data |
| rd_perr | output | 1 | Head character parity error tag |
| rd_ferr | output | 1 | Head character framing error tag |
| rd_brk | output | 1 | Head character break tag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
If the bit counter or the sample phase is off, the head shows a shifted or corrupted data value. It also shows a false framing tag. Both appear as soon as the next frame has been queued, about ten bit times after its start. A wrong parity sense or mask shows up on `rd_perr` for the very next frame that carries parity. Errors in the queue pointers or count show up within a few pops: characters come out in the wrong order, an extra character appears after an overrun, or `rd_valid` rises after popping an empty queue. A receiver left stuck after a break or a glitch shows up as a missing character on the frame that follows.

// File: rtl/rxl_pkg.sv
package rxl_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OVS    = 16;
    localparam int unsigned CNT_W  = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD
    } rx_state_e;

    // parity bit a correct sender would append
    function automatic logic parity_bit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // index of the final data bit for a word length code (0 -> 5 bits)
    function automatic logic [2:0] last_index(input logic [1:0] wl);
        return 3'(wl) + 3'd4;
    endfunction

endpackage

// File: rtl/rxl_framer.sv
module rxl_framer
    import rxl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic [1:0] cfg_wlen,
    input  logic     cfg_par_en,
    input  logic     cfg_par_odd,
    output logic     push_v,
    output rx_char_t push_c
);

    logic [1:0]        sync_q;
    logic              rxd_s;
    logic              prev_q;
    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [2:0]        bitn;
    logic [DATA_W-1:0] shreg;
    logic              zeros;
    logic              par_s;

    assign rxd_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            prev_q <= 1'b0;
            state  <= S_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            zeros  <= 1'b0;
            par_s  <= 1'b0;
            push_v <= 1'b0;
            push_c <= '0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            push_v <= 1'b0;
            if (tick) begin
                prev_q <= rxd_s;
                unique case (state)
                    S_IDLE: begin
                        if (prev_q && !rxd_s) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == MID_CNT) begin
                            cnt <= '0;
                            if (!rxd_s) begin
                                state <= S_DATA;
                                bitn  <= '0;
                                shreg <= '0;
                                zeros <= 1'b1;
                            end else begin
                                state <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == FULL_CNT) begin
                            cnt         <= '0;
                            shreg[bitn] <= rxd_s;
                            zeros       <= zeros & ~rxd_s;
                            if (bitn == last_index(cfg_wlen))
                                state <= cfg_par_en ? S_PAR : S_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == FULL_CNT) begin
                            cnt   <= '0;
                            par_s <= rxd_s;
                            zeros <= zeros & ~rxd_s;
                            state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == FULL_CNT) begin
                            cnt    <= '0;
                            push_v <= 1'b1;
                            if (zeros && !rxd_s) begin
                                push_c <= '{data: '0, perr: 1'b0, ferr: 1'b1, brk: 1'b1};
                                state  <= S_HOLD;
                            end else begin
                                push_c.data <= shreg;
                                push_c.perr <= cfg_par_en &&
                                               (par_s != parity_bit(shreg, cfg_par_odd));
                                push_c.ferr <= ~rxd_s;
                                push_c.brk  <= 1'b0;
                                state       <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_HOLD: begin
                        if (rxd_s) state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R2: a start bit found high at its mid-point sends the receiver back to idle
    p_glitch_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && state == S_START && cnt == MID_CNT && rxd_s) |=> state == S_IDLE);

    // R5: a character is only handed over after the stop bit phase
    p_push_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
        push_v |-> $past(state) == S_STOP);

    // R6: while waiting for the line to rise after a break, nothing more is queued
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD && $past(state) == S_HOLD) |-> !push_v);

endmodule

// File: rtl/rxl_fifo.sv
module rxl_fifo
    import rxl_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_v,
    input  rx_char_t wr_c,
    input  logic     rd,
    output rx_char_t head,
    output logic     nonempty,
    output logic     full
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   count;
    logic            do_wr, do_rd;

    assign nonempty = (count != '0);
    assign full     = (count == CW'(DEPTH));
    assign do_wr    = wr_v && !full;
    assign do_rd    = rd && nonempty;
    assign head     = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else begin
            if (do_wr) begin
                mem[wp] <= wr_c;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: a write into a full queue leaves the occupancy unchanged
    p_full_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (full && wr_v && !rd) |=> count == $past(count));

    // R10: popping an empty queue does not underflow it
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (!nonempty && rd && !wr_v) |=> !nonempty);

endmodule

// File: rtl/rx_line_unit.sv
module rx_line_unit
    import rxl_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              rxd,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rd_pop,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              rd_brk,
    output logic              ovr_err
);

    logic     push_v;
    rx_char_t push_c;
    rx_char_t head;
    logic     q_full;

    rxl_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .rxd         (rxd),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .push_v      (push_v),
        .push_c      (push_c)
    );

    rxl_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_v     (push_v),
        .wr_c     (push_c),
        .rd       (rd_pop),
        .head     (head),
        .nonempty (rd_valid),
        .full     (q_full)
    );

    always_ff @(posedge clk) begin
        if (rst)                   ovr_err <= 1'b0;
        else if (push_v && q_full) ovr_err <= 1'b1;
        else if (rd_pop)           ovr_err <= 1'b0;
    end

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
    assign rd_brk  = head.brk;

    // R8: a character arriving at a full queue raises the overrun flag
    p_ovr_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (push_v && q_full) |=> ovr_err);

    // R9: the overrun flag holds until a pop
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovr_err && !rd_pop) |=> ovr_err);

endmodule

// File: tb/test_rx_line_unit.sv
module test_rx_line_unit;

    localparam int BIT_CLK = 64;  // 16 ticks of 4 clocks each

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, ovr_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rx_line_unit #(.DEPTH(4)) i_rx_line_unit (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk), .ovr_err(ovr_err)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input int nbits,
                             input bit bad_par, input logic stop_v);
        logic [7:0] m;
        logic p;
        m = d & 8'((1 << nbits) - 1);
        cfg_wlen = 2'(nbits - 5);
        p = (^m) ^ cfg_par_odd ^ bad_par;
        line_bit(1'b0);
        for (int i = 0; i < nbits; i++) line_bit(m[i]);
        if (cfg_par_en) line_bit(p);
        line_bit(stop_v);
        line_bit(1'b1);
        line_bit(1'b1);
    endtask

    task automatic pop_one;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_head(input string req, input logic [7:0] d,
                               input logic pe, input logic fe, input logic bk);
        chk({req, " valid"}, int'(rd_valid), 1);
        chk({req, " data"},  int'(rd_data), int'(d));
        chk({req, " perr"},  int'(rd_perr), int'(pe));
        chk({req, " ferr"},  int'(rd_ferr), int'(fe));
        chk({req, " brk"},   int'(rd_brk), int'(bk));
    endtask

    task automatic t_reset;
        chk("R1 valid after reset", int'(rd_valid), 0);
        chk("R1 ovr after reset", int'(ovr_err), 0);
    endtask

    task automatic t_word_lengths;
        cfg_par_en = 1'b0;
        send_char(8'hA5, 8, 1'b0, 1'b1);
        expect_head("R3 8-bit A5", 8'hA5, 0, 0, 0);
        pop_one();
        send_char(8'h3C, 8, 1'b0, 1'b1);
        expect_head("R3 8-bit 3C", 8'h3C, 0, 0, 0);
        pop_one();
        send_char(8'hFF, 5, 1'b0, 1'b1);
        expect_head("R3 5-bit upper zero", 8'h1F, 0, 0, 0);
        pop_one();
        send_char(8'h41, 7, 1'b0, 1'b1);
        expect_head("R3 7-bit", 8'h41, 0, 0, 0);
        pop_one();
        chk("R7 drained", int'(rd_valid), 0);
    endtask

    task automatic t_parity;
        cfg_par_en = 1'b1;
        cfg_par_odd = 1'b0;
        send_char(8'h07, 8, 1'b0, 1'b1);
        expect_head("R4 even ok", 8'h07, 0, 0, 0);
        pop_one();
        send_char(8'h07, 8, 1'b1, 1'b1);
        expect_head("R4 even bad", 8'h07, 1, 0, 0);
        pop_one();
        cfg_par_odd = 1'b1;
        send_char(8'h12, 6, 1'b0, 1'b1);
        expect_head("R4 odd ok", 8'h12, 0, 0, 0);
        pop_one();
        send_char(8'h12, 6, 1'b1, 1'b1);
        expect_head("R4 odd bad", 8'h12, 1, 0, 0);
        pop_one();
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;
    endtask

    task automatic t_framing;
        send_char(8'h5A, 8, 1'b0, 1'b0);
        expect_head("R5 stop low", 8'h5A, 0, 1, 0);
        pop_one();
        chk("R5 one char", int'(rd_valid), 0);
    endtask

    task automatic t_glitch;
        rxd = 1'b0;
        repeat (16) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CLK) @(negedge clk);
        chk("R2 glitch ignored", int'(rd_valid), 0);
        send_char(8'hC3, 8, 1'b0, 1'b1);
        expect_head("R2 next frame ok", 8'hC3, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_break;
        rxd = 1'b0;
        repeat (24 * BIT_CLK) @(negedge clk);
        expect_head("R6 break char", 8'h00, 0, 1, 1);
        pop_one();
        chk("R6 single break char", int'(rd_valid), 0);
        rxd = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        send_char(8'h81, 8, 1'b0, 1'b1);
        expect_head("R6 after break", 8'h81, 0, 0, 0);
        pop_one();
    endtask

    task automatic t_overrun;
        logic [7:0] vals [4];
        vals[0] = 8'h11; vals[1] = 8'h22; vals[2] = 8'h33; vals[3] = 8'h44;
        for (int i = 0; i < 4; i++) send_char(vals[i], 8, 1'b0, 1'b1);
        chk("R8 no ovr yet", int'(ovr_err), 0);
        send_char(8'h99, 8, 1'b0, 1'b1);
        chk("R8 ovr set", int'(ovr_err), 1);
        repeat (BIT_CLK) @(negedge clk);
        chk("R9 ovr held", int'(ovr_err), 1);
        for (int i = 0; i < 4; i++) begin
            expect_head("R8 kept order", vals[i], 0, 0, 0);
            pop_one();
            if (i == 0) chk("R9 ovr cleared by pop", int'(ovr_err), 0);
        end
        chk("R8 dropped char absent", int'(rd_valid), 0);
    endtask

    task automatic t_pop_empty;
        pop_one();
        pop_one();
        chk("R10 still empty", int'(rd_valid), 0);
        send_char(8'h6E, 8, 1'b0, 1'b1);
        expect_head("R10 queue intact", 8'h6E, 0, 0, 0);
        pop_one();
        chk("R10 empty again", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4 * BIT_CLK) @(negedge clk);
        t_reset();
        t_word_lengths();
        t_parity();
        t_framing();
        t_glitch();
        t_break();
        t_overrun();
        t_pop_empty();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule